// File: doc/BRIEF.md
# Timer Pin GPIO and Edge-Interrupt Unit

This unit owns the single I/O pin that belongs to one timer channel. Software configures it through two 32-bit words on a simple register bus: a control word that chooses the pin function, the output level, the output style, the capture edges and the interrupt enable, and a status word that holds the interrupt flags and the live pin level. The counting, compare and PWM engines are elsewhere. This unit decodes only the function field, so it can tell when the pin is a GPIO and when it is an edge-capture input.

In GPIO function the pin can be driven low or high, or left floating as an input. It can be driven push-pull, or open-drain, where a high level releases the pin. In capture function the pin is always an input. Its synchronised level is watched for the chosen edges. Each detected edge latches a flag, software clears the flag by writing a one to it, and the interrupt line is raised while any flag is set and interrupts are enabled.

Top module: `tpin_unit`

## Requirements
- R1: After reset the control word reads 0, the status flags read 0, `irq_o` is 0 and `pin_oe_o` is 0.
- R2: A write to the control word (`bus_sel_i`=0) is read back unchanged. Reads return the selected word one cycle after `bus_sel_i` is presented.
- R3: With function field bits [2:0]=4 (GPIO), drive field bits [5:4]=2'b10 drives the pin low and 2'b11 drives it high, with `pin_oe_o`=1 in both cases.
- R4: With control bit 9 set (open-drain), a high drive level gives `pin_oe_o`=0 and a low drive level gives `pin_oe_o`=1 with `pin_out_o`=0. Whenever open-drain is set, `pin_out_o` is never 1 while the pin is enabled.
- R5: In GPIO function with drive field 2'b00, `pin_oe_o` is 0.
- R6: Status bit 8 follows the pin level after a two-flop synchroniser.
- R7: In capture function (bits [2:0]=1) with edge field bits [17:16]=2'b01, a rising pin edge sets status bit 0 and a falling edge does not.
- R8: With edge field 2'b10, only falling edges set status bit 0.
- R9: With edge field 2'b11, both edges set status bit 0. With 2'b00, no edge sets it.
- R10: When the function is not capture, pin edges set no flag.
- R11: `irq_o` is 1 exactly when any of status bits [3:0] is set and control bit 8 (interrupt enable) is 1.
- R12: Writing the status word (`bus_sel_i`=1) clears each flag whose data bit is 1. Flags whose data bit is 0 are left as they were.
- R13: If a write-one clear and a newly detected edge land in the same cycle, the flag stays set.
- R14: In capture function, `pin_oe_o` is 0 whatever the drive field holds.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| bus_wr_i | input | 1 | Register write strobe |
| bus_sel_i | input | 1 | Register select: 0 control word, 1 status word |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data for the selected word, registered |
| pin_i | input | 1 | Pin level from the pad (asynchronous) |
| pin_out_o | output | 1 | Pin output level |
| pin_oe_o | output | 1 | Pin output enable |
| irq_o | output | 1 | Interrupt request |

## Verification
The hardest case to reach is the race in which a write-one clear and a fresh edge hit the flag register in the same cycle. The edge only becomes visible two synchroniser stages after the pin moves. The bench therefore changes the pin on a falling clock edge, lets exactly two more falling edges pass, and then holds the status write for one cycle, so that the clear meets the edge pulse at the same rising edge. The flag must still read as set afterwards. A separate case confirms that the same write clears the flag when no edge is present.

// File: rtl/tpin_pkg.sv
package tpin_pkg;
  localparam int unsigned WORD_W   = 32;
  localparam int unsigned FLAG_W   = 4;
  // control word field positions
  localparam int unsigned FN_LSB   = 0;
  localparam int unsigned FN_W     = 3;
  localparam int unsigned DRV_LSB  = 4;
  localparam int unsigned IE_BIT   = 8;
  localparam int unsigned OD_BIT   = 9;
  localparam int unsigned EDGE_LSB = 16;
  // status word field positions
  localparam int unsigned LVL_BIT  = 8;

  typedef enum logic [FN_W-1:0] {
    FN_OFF     = 3'd0,
    FN_CAPTURE = 3'd1,
    FN_COMPARE = 3'd2,
    FN_PWM     = 3'd3,
    FN_GPIO    = 3'd4
  } pin_fn_e;

  typedef enum logic {
    SEL_CTRL   = 1'b0,
    SEL_STATUS = 1'b1
  } reg_sel_e;
endpackage

// File: rtl/tpin_sync_edge.sv
module tpin_sync_edge #(
  parameter int unsigned STAGES = 2
) (
  input  logic       clk_i,
  input  logic       rst_i,
  input  logic       pin_i,
  input  logic       cap_en_i,
  input  logic [1:0] edge_sel_i,
  output logic       level_o,
  output logic       hit_o
);
  logic [STAGES-1:0] stage_q;
  logic              prev_q;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= 1'b0;
        else       stage_q[g] <= pin_i;
      end
    end else begin : g_rest
      always_ff @(posedge clk_i) begin
        if (rst_i) stage_q[g] <= 1'b0;
        else       stage_q[g] <= stage_q[g-1];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) prev_q <= 1'b0;
    else       prev_q <= stage_q[STAGES-1];
  end

  logic rise, fall;
  assign level_o = stage_q[STAGES-1];
  assign rise    = level_o & ~prev_q;
  assign fall    = ~level_o & prev_q;
  assign hit_o   = cap_en_i & ((edge_sel_i[0] & rise) | (edge_sel_i[1] & fall));
endmodule

// File: rtl/tpin_regs.sv
module tpin_regs
  import tpin_pkg::*;
#(
  parameter int unsigned W  = WORD_W,
  parameter int unsigned FW = FLAG_W
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         wr_i,
  input  logic         sel_i,
  input  logic [W-1:0] wdata_i,
  input  logic         hit_i,
  input  logic         level_i,
  output logic [W-1:0] mode_d_o,
  output logic [W-1:0] mode_q_o,
  output logic [FW-1:0] flags_q_o,
  output logic         irq_o,
  output logic [W-1:0] rdata_o
);
  logic [W-1:0]  mode_q, mode_d;
  logic [FW-1:0] flags_q, flags_d, clr_mask, set_mask;
  logic [W-1:0]  status_word;

  always_comb begin
    mode_d = mode_q;
    if (wr_i && sel_i == SEL_CTRL) mode_d = wdata_i;
  end

  always_comb begin
    clr_mask = '0;
    if (wr_i && sel_i == SEL_STATUS) clr_mask = wdata_i[FW-1:0];
    set_mask = '0;
    set_mask[0] = hit_i;
    // set has priority over a simultaneous clear
    flags_d = (flags_q & ~clr_mask) | set_mask;
  end

  always_comb begin
    status_word = '0;
    status_word[FW-1:0] = flags_q;
    status_word[LVL_BIT] = level_i;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      mode_q  <= '0;
      flags_q <= '0;
      irq_o   <= 1'b0;
      rdata_o <= '0;
    end else begin
      mode_q  <= mode_d;
      flags_q <= flags_d;
      irq_o   <= (|flags_d) & mode_d[IE_BIT];
      rdata_o <= (sel_i == SEL_STATUS) ? status_word : mode_q;
    end
  end

  assign mode_d_o  = mode_d;
  assign mode_q_o  = mode_q;
  assign flags_q_o = flags_q;
endmodule

// File: rtl/tpin_drive.sv
module tpin_drive
  import tpin_pkg::*;
(
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic [FN_W-1:0] fn_i,
  input  logic [1:0]      drv_i,
  input  logic            od_i,
  output logic            pin_out_o,
  output logic            pin_oe_o
);
  logic oe_d, out_d;

  always_comb begin
    oe_d  = 1'b0;
    out_d = 1'b0;
    if (fn_i == FN_GPIO && drv_i[1]) begin
      if (od_i) begin
        oe_d  = ~drv_i[0];
        out_d = 1'b0;
      end else begin
        oe_d  = 1'b1;
        out_d = drv_i[0];
      end
    end
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      pin_oe_o  <= 1'b0;
      pin_out_o <= 1'b0;
    end else begin
      pin_oe_o  <= oe_d;
      pin_out_o <= out_d;
    end
  end
endmodule

// File: rtl/tpin_unit.sv
module tpin_unit
  import tpin_pkg::*;
#(
  parameter int unsigned W           = WORD_W,
  parameter int unsigned FW          = FLAG_W,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic         clk_i,
  input  logic         rst_i,
  input  logic         bus_wr_i,
  input  logic         bus_sel_i,
  input  logic [W-1:0] bus_wdata_i,
  output logic [W-1:0] bus_rdata_o,
  input  logic         pin_i,
  output logic         pin_out_o,
  output logic         pin_oe_o,
  output logic         irq_o
);
  logic [W-1:0]  mode_d, mode_q;
  logic [FW-1:0] flags_q;
  logic          edge_hit, pin_level, cap_en;

  assign cap_en = (mode_q[FN_LSB +: FN_W] == FN_CAPTURE);

  tpin_sync_edge #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i      (clk_i),
    .rst_i      (rst_i),
    .pin_i      (pin_i),
    .cap_en_i   (cap_en),
    .edge_sel_i (mode_q[EDGE_LSB +: 2]),
    .level_o    (pin_level),
    .hit_o      (edge_hit)
  );

  tpin_regs #(.W(W), .FW(FW)) u_regs (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .wr_i      (bus_wr_i),
    .sel_i     (bus_sel_i),
    .wdata_i   (bus_wdata_i),
    .hit_i     (edge_hit),
    .level_i   (pin_level),
    .mode_d_o  (mode_d),
    .mode_q_o  (mode_q),
    .flags_q_o (flags_q),
    .irq_o     (irq_o),
    .rdata_o   (bus_rdata_o)
  );

  tpin_drive u_drive (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .fn_i      (mode_d[FN_LSB +: FN_W]),
    .drv_i     (mode_d[DRV_LSB +: 2]),
    .od_i      (mode_d[OD_BIT]),
    .pin_out_o (pin_out_o),
    .pin_oe_o  (pin_oe_o)
  );
endmodule

// File: rtl/tpin_unit_chk.sv
module tpin_unit_chk
  import tpin_pkg::*;
(
  input logic        clk,
  input logic        rst,
  input logic        irq,
  input logic        pin_oe,
  input logic        pin_out,
  input logic [31:0] mode,
  input logic [3:0]  flags,
  input logic        hit,
  input logic        wclr0
);
  assert_irq_needs_enable_R11: assert property (@(posedge clk) disable iff (rst)
    irq |-> (mode[IE_BIT] && (|flags)));
  assert_irq_when_pending_R11: assert property (@(posedge clk) disable iff (rst)
    (mode[IE_BIT] && (|flags)) |-> irq);
  assert_capture_input_R14: assert property (@(posedge clk) disable iff (rst)
    (mode[2:0] == FN_CAPTURE) |-> !pin_oe);
  assert_od_never_high_R4: assert property (@(posedge clk) disable iff (rst)
    (pin_oe && mode[OD_BIT]) |-> !pin_out);
  assert_edge_wins_R13: assert property (@(posedge clk) disable iff (rst)
    hit |=> flags[0]);
  assert_clear_R12: assert property (@(posedge clk) disable iff (rst)
    (wclr0 && !hit) |=> !flags[0]);
  assert_capture_only_R10: assert property (@(posedge clk) disable iff (rst)
    $rose(flags[0]) |-> $past(mode[2:0] == FN_CAPTURE));
endmodule

bind tpin_unit tpin_unit_chk u_chk (
  .clk     (clk_i),
  .rst     (rst_i),
  .irq     (irq_o),
  .pin_oe  (pin_oe_o),
  .pin_out (pin_out_o),
  .mode    (mode_q),
  .flags   (flags_q),
  .hit     (edge_hit),
  .wclr0   (bus_wr_i && bus_sel_i && bus_wdata_i[0])
);

// File: tb/test_tpin_unit.sv
module test_tpin_unit;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr = 1'b0;
  logic        sel = 1'b0;
  logic [31:0] wdata = '0;
  logic [31:0] rdata;
  logic        pin = 1'b0;
  logic        pout, poe, irq;
  int          n_checks = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  always #10 clk = ~clk;

  tpin_unit i_tpin_unit (
    .clk_i(clk), .rst_i(rst), .bus_wr_i(wr), .bus_sel_i(sel),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .pin_i(pin),
    .pin_out_o(pout), .pin_oe_o(poe), .irq_o(irq)
  );

  localparam logic [31:0] CAP = 32'h1, GPIO = 32'h4;
  localparam logic [31:0] IE = 32'h100, OD = 32'h200;
  localparam logic [31:0] E_R = 32'h1_0000, E_F = 32'h2_0000, E_B = 32'h3_0000;

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr_reg(input logic s, input logic [31:0] d);
    @(negedge clk); wr = 1'b1; sel = s; wdata = d;
    @(negedge clk); wr = 1'b0; wdata = '0;
  endtask

  task automatic rd_reg(input logic s, output logic [31:0] d);
    @(negedge clk); sel = s;
    @(negedge clk); d = rdata;
  endtask

  task automatic set_pin(input logic v);
    @(negedge clk); pin = v;
    repeat (4) @(negedge clk);
  endtask

  task automatic flag0(input string req, input logic exp);
    logic [31:0] d;
    rd_reg(1'b1, d);
    check(req, {31'b0, d[0]}, {31'b0, exp});
  endtask

  task automatic t_reset;
    logic [31:0] d;
    rd_reg(1'b0, d); check("R1 ctrl", d, 32'h0);
    rd_reg(1'b1, d); check("R1 status", d & 32'hF, 32'h0);
    check("R1 irq", {31'b0, irq}, 32'h0);
    check("R1 oe", {31'b0, poe}, 32'h0);
  endtask

  task automatic t_ctrl_rw;
    logic [31:0] d;
    wr_reg(1'b0, 32'hA5C3_0F3B); rd_reg(1'b0, d); check("R2 readback", d, 32'hA5C3_0F3B);
    wr_reg(1'b0, 32'h0);         rd_reg(1'b0, d); check("R2 readback zero", d, 32'h0);
  endtask

  task automatic t_gpio;
    wr_reg(1'b0, GPIO | 32'h20); @(negedge clk);
    check("R3 low oe", {31'b0, poe}, 32'h1); check("R3 low out", {31'b0, pout}, 32'h0);
    wr_reg(1'b0, GPIO | 32'h30); @(negedge clk);
    check("R3 high oe", {31'b0, poe}, 32'h1); check("R3 high out", {31'b0, pout}, 32'h1);
    wr_reg(1'b0, GPIO | OD | 32'h30); @(negedge clk);
    check("R4 od high released", {31'b0, poe}, 32'h0);
    wr_reg(1'b0, GPIO | OD | 32'h20); @(negedge clk);
    check("R4 od low oe", {31'b0, poe}, 32'h1); check("R4 od low out", {31'b0, pout}, 32'h0);
    wr_reg(1'b0, GPIO); @(negedge clk);
    check("R5 input", {31'b0, poe}, 32'h0);
  endtask

  task automatic t_level;
    logic [31:0] d;
    set_pin(1'b1); rd_reg(1'b1, d); check("R6 level high", {31'b0, d[8]}, 32'h1);
    set_pin(1'b0); rd_reg(1'b1, d); check("R6 level low", {31'b0, d[8]}, 32'h0);
  endtask

  task automatic t_rise;
    wr_reg(1'b0, CAP | E_R);
    set_pin(1'b1); flag0("R7 rising sets", 1'b1);
    check("R11 no irq without enable", {31'b0, irq}, 32'h0);
    wr_reg(1'b1, 32'h1); flag0("R12 w1c clears", 1'b0);
    set_pin(1'b0); flag0("R7 falling ignored", 1'b0);
  endtask

  task automatic t_fall;
    wr_reg(1'b0, CAP | E_F);
    set_pin(1'b1); flag0("R8 rising ignored", 1'b0);
    set_pin(1'b0); flag0("R8 falling sets", 1'b1);
    wr_reg(1'b1, 32'hF);
  endtask

  task automatic t_both;
    wr_reg(1'b0, CAP | E_B);
    set_pin(1'b1); flag0("R9 both rise", 1'b1);
    wr_reg(1'b1, 32'h1);
    set_pin(1'b0); flag0("R9 both fall", 1'b1);
    wr_reg(1'b1, 32'h1);
    wr_reg(1'b0, CAP);
    set_pin(1'b1); set_pin(1'b0); flag0("R9 none selected", 1'b0);
  endtask

  task automatic t_nocap;
    wr_reg(1'b0, GPIO | E_B);
    set_pin(1'b1); set_pin(1'b0); flag0("R10 gpio no capture", 1'b0);
    wr_reg(1'b0, E_B);
    set_pin(1'b1); set_pin(1'b0); flag0("R10 off no capture", 1'b0);
  endtask

  task automatic t_irq;
    wr_reg(1'b0, CAP | E_R | IE);
    set_pin(1'b1); @(negedge clk);
    check("R11 irq raised", {31'b0, irq}, 32'h1);
    wr_reg(1'b1, 32'h0); flag0("R12 zero write keeps flag", 1'b1);
    wr_reg(1'b0, CAP | E_R); @(negedge clk);
    check("R11 masked", {31'b0, irq}, 32'h0);
    wr_reg(1'b0, CAP | E_R | IE); @(negedge clk);
    check("R11 unmasked", {31'b0, irq}, 32'h1);
    wr_reg(1'b1, 32'h1); @(negedge clk);
    check("R11 drops after clear", {31'b0, irq}, 32'h0);
    set_pin(1'b0);
  endtask

  task automatic t_race;
    wr_reg(1'b0, CAP | E_R);
    flag0("R13 precondition clear", 1'b0);
    @(negedge clk); pin = 1'b1;
    @(negedge clk);
    @(negedge clk); wr = 1'b1; sel = 1'b1; wdata = 32'h1;
    @(negedge clk); wr = 1'b0; wdata = '0;
    flag0("R13 edge beats clear", 1'b1);
    wr_reg(1'b1, 32'h1);
    set_pin(1'b0);
  endtask

  task automatic t_cap_pin;
    wr_reg(1'b0, CAP | E_B | 32'h30); @(negedge clk);
    check("R14 capture forces input", {31'b0, poe}, 32'h0);
    wr_reg(1'b0, CAP | E_B | 32'h20); @(negedge clk);
    check("R14 capture low ignored", {31'b0, poe}, 32'h0);
  endtask

  task automatic finish_run;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_ctrl_rw();
    t_gpio();
    t_level();
    t_rise();
    t_fall();
    t_both();
    t_nocap();
    t_irq();
    t_race();
    t_cap_pin();
    done = 1'b1;
    finish_run();
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
    end
  end
endmodule